// File: doc/BRIEF.md
# Oscillator Clock Failure Detector

This block decides whether a fast crystal oscillator clock is still running. It uses a much slower, free-running RC clock as its time base. Each high phase of the slow clock is one measurement window. An edge counter in the fast domain is held at zero while the slow clock is low and counts fast rising edges while it is high. The counter saturates at a small threshold. When the slow clock falls, the window closes and its verdict is "enough edges" or "too few edges".

The verdict crosses into the slow domain through a short synchronizer clocked on the slow-clock falling edge. A registered verdict stage then drives two outputs. One is a live failure level. The other is a single-cycle pulse that marks each change from healthy to failed. Detection runs only while the enable input is high and the oscillator-on indication is high. If either is low, the slow-domain stages are held in the healthy state. A synchronous active-high reset does the same.

Top module: `cfd_monitor`

## Requirements
- R1: While `rst_i` is high at a slow-clock falling edge, both outputs are low after that edge.
- R2: A window with fewer than MIN_EDGES (default 8) fast rising edges drives `fail_level_o` high. The change appears after the third slow-clock falling edge, counting the window's own closing edge, provided detection stayed active throughout.
- R3: A window with MIN_EDGES or more edges, including exactly MIN_EDGES, is reported healthy with the same latency as R2.
- R4: Fast edges that arrive while `sclk_i` is low are not counted toward the next window.
- R5: The edge counter saturates at MIN_EDGES. Any number of edges from MIN_EDGES up to 45 in one window gives a healthy verdict.
- R6: `fail_pulse_o` is high for exactly one slow-clock cycle on each change from healthy to failed, and only when `fail_level_o` is high in the same cycle. It does not repeat while the failure persists.
- R7: While `det_en_i` is low, both outputs are low, whatever the fast clock does.
- R8: While `osc_on_i` is low, both outputs are low even when `det_en_i` is high.
- R9: After a failure, a window with MIN_EDGES or more edges clears `fail_level_o` with the latency of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk_i | input | 1 | Monitored fast oscillator clock |
| sclk_i | input | 1 | Slow RC reference clock; its high phase is the window |
| rst_i | input | 1 | Synchronous active-high reset, slow domain |
| det_en_i | input | 1 | Detection enable |
| osc_on_i | input | 1 | High while the monitored oscillator is switched on |
| fail_pulse_o | output | 1 | One slow-cycle pulse when a failure is first reported |
| fail_level_o | output | 1 | Live failure status |

## Verification
The bench builds the block with its defaults: MIN_EDGES of 8 and a two-stage synchronizer. With these values every edge count from zero up to the threshold and well past it can be placed in a single window. The bench generates each fast edge itself, so a window holds an exact count. It sweeps counts 0 to 12 around the threshold, counts above 16 that would expose a wrapping counter, and edges placed in the low phase. It also toggles the enable and oscillator-on inputs both in the middle of a failure and outside one.

// File: rtl/cfd_pkg.sv
`timescale 1ns/1ps
package cfd_pkg;
  // Verdict state held in the slow domain.
  typedef enum logic {
    ST_HEALTHY = 1'b0,
    ST_FAILED  = 1'b1
  } cfd_state_e;

  // Width needed to hold 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/cfd_edge_counter.sv
`timescale 1ns/1ps
// Fast-domain edge counter: async clear while the window is closed,
// saturating count while it is open.
module cfd_edge_counter #(
  parameter int MIN_EDGES = 8,
  parameter int CW        = 4
) (
  input  logic          fclk_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          enough_o
);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_EDGES);

  always_ff @(posedge fclk_i or posedge clr_i) begin
    if (clr_i)
      cnt_o <= '0;
    else if (cnt_o != LIMIT)
      cnt_o <= cnt_o + 1'b1;
  end

  assign enough_o = (cnt_o == LIMIT);
endmodule

// File: rtl/cfd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with a synchronous preset to '1 (healthy).
// STAGES must be 2 or more.
module cfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic preset_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i) begin
    if (preset_i)
      chain <= '1;
    else
      chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cfd_verdict.sv
`timescale 1ns/1ps
// Slow-domain verdict: status register plus a healthy-to-failed pulse.
module cfd_verdict
  import cfd_pkg::*;
(
  input  logic clk_i,
  input  logic hold_i,
  input  logic ok_i,
  output logic fail_o,
  output logic pulse_o
);
  cfd_state_e state_q;

  always_ff @(posedge clk_i) begin
    if (hold_i) begin
      state_q <= ST_HEALTHY;
      pulse_o <= 1'b0;
    end else begin
      state_q <= ok_i ? ST_HEALTHY : ST_FAILED;
      pulse_o <= !ok_i && (state_q == ST_HEALTHY);
    end
  end

  assign fail_o = (state_q == ST_FAILED);
endmodule

// File: rtl/cfd_monitor.sv
`timescale 1ns/1ps
module cfd_monitor #(
  parameter int MIN_EDGES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic fclk_i,
  input  logic sclk_i,
  input  logic rst_i,
  input  logic det_en_i,
  input  logic osc_on_i,
  output logic fail_pulse_o,
  output logic fail_level_o
);
  localparam int CW = cfd_pkg::cnt_width(MIN_EDGES);

  // Slow-domain logic runs on the falling edge of the reference, i.e. at
  // the close of each window; the same edge starts the counter clear.
  logic sclk_n;
  logic hold;
  logic [CW-1:0] edge_cnt;
  logic enough_raw;
  logic enough_s;

  assign sclk_n = ~sclk_i;
  assign hold   = rst_i | ~(det_en_i & osc_on_i);

  cfd_edge_counter #(
    .MIN_EDGES (MIN_EDGES),
    .CW        (CW)
  ) u_cnt (
    .fclk_i   (fclk_i),
    .clr_i    (sclk_n),
    .cnt_o    (edge_cnt),
    .enough_o (enough_raw)
  );

  cfd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i    (sclk_n),
    .preset_i (hold),
    .d_i      (enough_raw),
    .q_o      (enough_s)
  );

  cfd_verdict u_verdict (
    .clk_i   (sclk_n),
    .hold_i  (hold),
    .ok_i    (enough_s),
    .fail_o  (fail_level_o),
    .pulse_o (fail_pulse_o)
  );
endmodule

// File: rtl/cfd_monitor_chk.sv
`timescale 1ns/1ps
module cfd_monitor_chk #(
  parameter int MIN_EDGES = 8,
  parameter int CW        = 4
) (
  input logic          fclk_i,
  input logic          sclk_i,
  input logic          rst_i,
  input logic          det_en_i,
  input logic          osc_on_i,
  input logic          fail_pulse_o,
  input logic          fail_level_o,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_EDGES);

  // R1
  reset_clears_chk: assert property (@(negedge sclk_i)
    rst_i |=> (!fail_level_o && !fail_pulse_o));

  // R4
  low_phase_clear_chk: assert property (@(posedge fclk_i) disable iff (rst_i)
    !sclk_i |-> (cnt == '0));

  // R5
  no_overflow_chk: assert property (@(posedge fclk_i) disable iff (rst_i)
    cnt <= LIMIT);

  // R6
  pulse_single_chk: assert property (@(negedge sclk_i) disable iff (rst_i)
    fail_pulse_o |=> !fail_pulse_o);

  // R6
  pulse_with_level_chk: assert property (@(negedge sclk_i) disable iff (rst_i)
    fail_pulse_o |-> fail_level_o);

  // R6
  rise_gives_pulse_chk: assert property (@(negedge sclk_i) disable iff (rst_i)
    $rose(fail_level_o) |-> fail_pulse_o);

  // R7
  disabled_quiet_chk: assert property (@(negedge sclk_i) disable iff (rst_i)
    !det_en_i |=> (!fail_level_o && !fail_pulse_o));

  // R8
  osc_off_quiet_chk: assert property (@(negedge sclk_i) disable iff (rst_i)
    !osc_on_i |=> (!fail_level_o && !fail_pulse_o));
endmodule

bind cfd_monitor cfd_monitor_chk #(
  .MIN_EDGES (MIN_EDGES),
  .CW        (CW)
) u_chk (
  .fclk_i       (fclk_i),
  .sclk_i       (sclk_i),
  .rst_i        (rst_i),
  .det_en_i     (det_en_i),
  .osc_on_i     (osc_on_i),
  .fail_pulse_o (fail_pulse_o),
  .fail_level_o (fail_level_o),
  .cnt          (edge_cnt)
);

// File: tb/cfd_monitor_tb.sv
`timescale 1ns/1ps
module cfd_monitor_tb;
  localparam int SCLK_PERIOD = 2000;
  localparam int HALF        = SCLK_PERIOD / 2;
  localparam int FCLK_PERIOD = 20;
  localparam int LEAD        = 50;
  localparam int MIN_EDGES   = 8;
  localparam longint WATCHDOG = 64'd2000000;

  logic fclk = 1'b0;
  logic sclk = 1'b0;
  logic rst  = 1'b1;
  logic en   = 1'b0;
  logic osc  = 1'b1;
  logic fail_pulse, fail_level;

  int checks = 0;
  int fails  = 0;

  // Window-level expectation: a verdict reaches the outputs at the third
  // falling edge after its window closes; inactive detection reads healthy.
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_fail = 1'b0, m_pulse = 1'b0;

  cfd_monitor #(
    .MIN_EDGES   (MIN_EDGES),
    .SYNC_STAGES (2)
  ) u_dut (
    .fclk_i       (fclk),
    .sclk_i       (sclk),
    .rst_i        (rst),
    .det_en_i     (en),
    .osc_on_i     (osc),
    .fail_pulse_o (fail_pulse),
    .fail_level_o (fail_level)
  );

  task automatic check(input string tag, input string what,
                       input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_close(input int n_high);
    logic nf, np;
    if (rst || !(en && osc)) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_fail = 1'b0; m_pulse = 1'b0;
    end else begin
      nf = !m_s2;
      np = !m_s2 && !m_fail;
      m_fail  = nf;
      m_pulse = np;
      m_s2 = m_s1;
      m_s1 = (n_high >= MIN_EDGES);
    end
  endtask

  task automatic fast_edges(input int n);
    repeat (n) begin
      fclk = 1'b1; #(FCLK_PERIOD/2);
      fclk = 1'b0; #(FCLK_PERIOD/2);
    end
  endtask

  // One slow period: n_high edges in the window, n_low edges after it,
  // outputs sampled late in the low phase.
  task automatic run_window(input int n_high, input int n_low, input string tag);
    sclk = 1'b1;
    #LEAD;
    fast_edges(n_high);
    #(HALF - LEAD - n_high*FCLK_PERIOD);
    sclk = 1'b0;
    model_close(n_high);
    #LEAD;
    fast_edges(n_low);
    #(HALF*3/4 - LEAD - n_low*FCLK_PERIOD);
    check(tag, "fail_level", fail_level, m_fail);
    check((tag == "R1" || tag == "R7" || tag == "R8") ? tag : "R6",
          "fail_pulse", fail_pulse, m_pulse);
    #(HALF/4);
  endtask

  initial begin
    #(WATCHDOG);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, even with detection enabled and no edges
    en = 1'b1;
    repeat (3) run_window(0, 0, "R1");
    rst = 1'b0;
    en  = 1'b0;
    // R7: disabled, oscillator dead
    repeat (3) run_window(0, 0, "R7");
    en = 1'b1;
    repeat (3) run_window(10, 0, "R3");
    // R2 / R3 sweep around the threshold, each followed by recovery (R9)
    for (int n = 0; n <= 12; n++) begin
      run_window(n, 0, (n < MIN_EDGES) ? "R2" : "R3");
      repeat (3) run_window(10, 0, "R9");
    end
    // R2 persistent failure, single pulse (R6)
    repeat (5) run_window(3, 0, "R2");
    repeat (3) run_window(MIN_EDGES, 0, "R9");
    // R4: low-phase edges do not help the next window
    repeat (4) run_window(5, 6, "R4");
    repeat (3) run_window(10, 9, "R4");
    // R5: saturation, no wrap
    for (int k = 16; k <= 45; k += 7) run_window(k, 0, "R5");
    run_window(16, 0, "R5");
    run_window(32, 0, "R5");
    repeat (2) run_window(12, 0, "R5");
    // R7: disable in the middle of a failure
    repeat (4) run_window(0, 0, "R2");
    en = 1'b0;
    repeat (3) run_window(0, 0, "R7");
    en = 1'b1;
    repeat (4) run_window(0, 0, "R2");
    // R8: oscillator switched off while enabled
    osc = 1'b0;
    repeat (4) run_window(0, 0, "R8");
    osc = 1'b1;
    repeat (3) run_window(10, 0, "R9");
    // alternating healthy and failed windows, pulses on each fall
    for (int k = 0; k < 6; k++) run_window((k % 2 == 0) ? 2 : 9, 0, "R6");
    repeat (3) run_window(10, 0, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule